// File: doc/BRIEF.md
# Peripheral Bus Fabric with Interrupt Gather

This block connects one 32-bit bus master to a set of peripheral slots. The top byte of the master address selects a slot. Only the selected slot receives the master's write enable, cycle, strobe, byte selects, write data and address. Every other slot sees all of these held at zero. The address a slot receives keeps only the low 24 bits, so each peripheral decodes a local offset.

Read data and acknowledge come back to the master from the selected slot through combinational multiplexers. An acknowledge therefore reaches the master in the same cycle the slave raises it. The interrupt line of each slot is packed into a 32-bit word. The master reads that word whenever it addresses a slot index that has no slave behind it, and no acknowledge is returned in that case.

A build option adds one further slot, numbered 0 and meant for a read-only description table. With this option the slot count is one more than the number of peripherals. The block holds no state; "reset" for it means an idle master with all inputs at zero.

Top module: `wbx_fabric`

## Requirements
- R1: The slot whose number equals master address bits [31:24] receives the master's we, cyc, stb, sel[3:0] and write data unchanged in the same cycle.
- R2: Every slot whose number differs from master address bits [31:24] sees we, cyc and stb at 0, and sel, write data and address at all zeros.
- R3: The address forwarded to the selected slot equals master address bits [23:0], with bits [31:24] forced to zero.
- R4: While a slot is selected, master read data equals that slot's read data and the master acknowledge equals that slot's acknowledge, in the same cycle.
- R5: When the index is at or above the slot count, the master acknowledge is 0 and no slot sees cyc, stb or we.
- R6: When the index is at or above the slot count, master read data bit i equals slot i's interrupt input, for i below the slot count, and every higher bit is 0.
- R7: With the description-table option enabled, the slot count is the peripheral count plus one, the highest slot number (equal to the peripheral count) is reachable, and the next index is unmapped.
- R8: At most one slot sees cyc asserted at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_mst_we | input | 1 | Master write enable |
| i_mst_cyc | input | 1 | Master bus cycle |
| i_mst_stb | input | 1 | Master strobe |
| i_mst_sel | input | 4 | Master byte selects |
| i_mst_adr | input | 32 | Master address; bits [31:24] pick the slot |
| i_mst_wdat | input | 32 | Master write data |
| o_mst_rdat | output | 32 | Read data to the master |
| o_mst_ack | output | 1 | Acknowledge to the master |
| o_slv_we | output | SLOTS | Per-slot write enable |
| o_slv_cyc | output | SLOTS | Per-slot bus cycle |
| o_slv_stb | output | SLOTS | Per-slot strobe |
| o_slv_sel | output | 4*SLOTS | Per-slot byte selects, slot i at [4i+3:4i] |
| o_slv_adr | output | 32*SLOTS | Per-slot local address, slot i at [32i+31:32i] |
| o_slv_wdat | output | 32*SLOTS | Per-slot write data, slot i at [32i+31:32i] |
| i_slv_ack | input | SLOTS | Per-slot acknowledge |
| i_slv_rdat | input | 32*SLOTS | Per-slot read data, slot i at [32i+31:32i] |
| i_slv_irq | input | SLOTS | Per-slot interrupt line |

## Verification
The bench builds the fabric with four peripherals and the description-table slot enabled, giving five slots. Slot 4 is then the top mapped index, and index 5 is the first unmapped one. Indices 5 through 255 all take the interrupt-read path. Because only five slots exist, the interrupt word has 27 tied-zero bits that are visible at the master. With the slot count below 32, both the off-by-one edge between mapped and unmapped indices and the zero padding of the interrupt word can be observed.

// File: rtl/wbx_pkg.sv
package wbx_pkg;
    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int SEL_W   = DATA_W / 8;
    localparam int IDX_W   = 8;
    localparam int LOCAL_W = ADDR_W - IDX_W;
    localparam int IRQ_W   = 32;
endpackage

// File: rtl/wbx_slot_decode.sv
module wbx_slot_decode
    import wbx_pkg::*;
#(
    parameter int SLOTS = 5
) (
    input  logic [IDX_W-1:0] idx,
    output logic [SLOTS-1:0] hit,
    output logic             mapped
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_hit
        assign hit[g] = (idx == IDX_W'(g));
    end
    assign mapped = |hit;
endmodule

// File: rtl/wbx_req_fanout.sv
module wbx_req_fanout
    import wbx_pkg::*;
#(
    parameter int SLOTS = 5
) (
    input  logic [SLOTS-1:0]        hit,
    input  logic                    we,
    input  logic                    cyc,
    input  logic                    stb,
    input  logic [SEL_W-1:0]        sel,
    input  logic [LOCAL_W-1:0]      adr_local,
    input  logic [DATA_W-1:0]       wdat,
    output logic [SLOTS-1:0]        slv_we,
    output logic [SLOTS-1:0]        slv_cyc,
    output logic [SLOTS-1:0]        slv_stb,
    output logic [SLOTS*SEL_W-1:0]  slv_sel,
    output logic [SLOTS*ADDR_W-1:0] slv_adr,
    output logic [SLOTS*DATA_W-1:0] slv_wdat
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign slv_we[g]  = hit[g] & we;
        assign slv_cyc[g] = hit[g] & cyc;
        assign slv_stb[g] = hit[g] & stb;
        assign slv_sel[g*SEL_W +: SEL_W]    = hit[g] ? sel : '0;
        assign slv_adr[g*ADDR_W +: ADDR_W]  = hit[g] ? {{IDX_W{1'b0}}, adr_local} : '0;
        assign slv_wdat[g*DATA_W +: DATA_W] = hit[g] ? wdat : '0;
    end
endmodule

// File: rtl/wbx_irq_pack.sv
module wbx_irq_pack
    import wbx_pkg::*;
#(
    parameter int SLOTS = 5
) (
    input  logic [SLOTS-1:0] irq,
    output logic [IRQ_W-1:0] vec
);
    assign vec = IRQ_W'(irq);
endmodule

// File: rtl/wbx_rsp_mux.sv
module wbx_rsp_mux
    import wbx_pkg::*;
#(
    parameter int SLOTS = 5
) (
    input  logic [SLOTS-1:0]        hit,
    input  logic                    mapped,
    input  logic [SLOTS-1:0]        slv_ack,
    input  logic [SLOTS*DATA_W-1:0] slv_rdat,
    input  logic [IRQ_W-1:0]        irq_vec,
    output logic [DATA_W-1:0]       rdat,
    output logic                    ack
);
    logic [DATA_W-1:0] acc;

    always_comb begin
        acc = '0;
        ack = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            if (hit[i]) begin
                acc = acc | slv_rdat[i*DATA_W +: DATA_W];
                ack = ack | slv_ack[i];
            end
        end
    end

    assign rdat = mapped ? acc : DATA_W'(irq_vec);
endmodule

// File: rtl/wbx_fabric.sv
module wbx_fabric
    import wbx_pkg::*;
#(
    parameter int NUM_PERIPH = 4,
    parameter bit ROM_SLOT   = 1'b1,
    localparam int SLOTS     = NUM_PERIPH + (ROM_SLOT ? 1 : 0)
) (
    input  logic                    i_mst_we,
    input  logic                    i_mst_cyc,
    input  logic                    i_mst_stb,
    input  logic [3:0]              i_mst_sel,
    input  logic [31:0]             i_mst_adr,
    input  logic [31:0]             i_mst_wdat,
    output logic [31:0]             o_mst_rdat,
    output logic                    o_mst_ack,
    output logic [SLOTS-1:0]        o_slv_we,
    output logic [SLOTS-1:0]        o_slv_cyc,
    output logic [SLOTS-1:0]        o_slv_stb,
    output logic [SLOTS*4-1:0]      o_slv_sel,
    output logic [SLOTS*32-1:0]     o_slv_adr,
    output logic [SLOTS*32-1:0]     o_slv_wdat,
    input  logic [SLOTS-1:0]        i_slv_ack,
    input  logic [SLOTS*32-1:0]     i_slv_rdat,
    input  logic [SLOTS-1:0]        i_slv_irq
);
    logic [SLOTS-1:0] hit;
    logic             mapped;
    logic [IRQ_W-1:0] irq_vec;

    wbx_slot_decode #(.SLOTS(SLOTS)) u_dec (
        .idx    (i_mst_adr[ADDR_W-1 -: IDX_W]),
        .hit    (hit),
        .mapped (mapped)
    );

    wbx_req_fanout #(.SLOTS(SLOTS)) u_req (
        .hit       (hit),
        .we        (i_mst_we),
        .cyc       (i_mst_cyc),
        .stb       (i_mst_stb),
        .sel       (i_mst_sel),
        .adr_local (i_mst_adr[LOCAL_W-1:0]),
        .wdat      (i_mst_wdat),
        .slv_we    (o_slv_we),
        .slv_cyc   (o_slv_cyc),
        .slv_stb   (o_slv_stb),
        .slv_sel   (o_slv_sel),
        .slv_adr   (o_slv_adr),
        .slv_wdat  (o_slv_wdat)
    );

    wbx_irq_pack #(.SLOTS(SLOTS)) u_irq (
        .irq (i_slv_irq),
        .vec (irq_vec)
    );

    wbx_rsp_mux #(.SLOTS(SLOTS)) u_rsp (
        .hit      (hit),
        .mapped   (mapped),
        .slv_ack  (i_slv_ack),
        .slv_rdat (i_slv_rdat),
        .irq_vec  (irq_vec),
        .rdat     (o_mst_rdat),
        .ack      (o_mst_ack)
    );
endmodule

// File: rtl/wbx_fabric_chk.sv
module wbx_fabric_chk #(
    parameter int SLOTS = 5
) (
    input logic                i_mst_we,
    input logic                i_mst_cyc,
    input logic                i_mst_stb,
    input logic [31:0]         i_mst_adr,
    input logic [31:0]         o_mst_rdat,
    input logic                o_mst_ack,
    input logic [SLOTS-1:0]    o_slv_we,
    input logic [SLOTS-1:0]    o_slv_cyc,
    input logic [SLOTS-1:0]    o_slv_stb,
    input logic [SLOTS*32-1:0] o_slv_adr,
    input logic [SLOTS-1:0]    i_slv_irq
);
    logic unmapped;
    assign unmapped = (int'(i_mst_adr[31:24]) >= SLOTS);

    always_comb begin
        // R8
        cyc_onehot_chk: assert ($onehot0(o_slv_cyc));
        if (unmapped) begin
            // R5
            unmapped_quiet_chk: assert (!o_mst_ack && o_slv_stb == '0 && o_slv_we == '0);
            // R6
            irq_word_chk: assert (o_mst_rdat == 32'(i_slv_irq));
        end
        for (int i = 0; i < SLOTS; i++) begin
            if (int'(i_mst_adr[31:24]) == i) begin
                // R1
                follow_chk: assert (o_slv_cyc[i] == i_mst_cyc && o_slv_stb[i] == i_mst_stb
                                    && o_slv_we[i] == i_mst_we);
                // R3
                local_adr_chk: assert (o_slv_adr[i*32 +: 32] == {8'h00, i_mst_adr[23:0]});
            end else begin
                // R2
                idle_slot_chk: assert (!o_slv_cyc[i] && !o_slv_stb[i] && !o_slv_we[i]
                                       && o_slv_adr[i*32 +: 32] == 32'h0);
            end
        end
    end
endmodule

bind wbx_fabric wbx_fabric_chk #(.SLOTS(SLOTS)) u_chk (.*);

// File: tb/wbx_fabric_test.sv
module wbx_fabric_test;
    localparam int NP = 4;
    localparam int S  = NP + 1;

    typedef struct packed {
        logic [7:0]  idx;
        logic        we;
        logic [3:0]  sel;
        logic [31:0] wdat;
        logic [23:0] lo;
    } vec_t;

    localparam vec_t TBL [8] = '{
        '{8'd0,   1'b0, 4'hF, 32'h1111_2222, 24'h000010},
        '{8'd1,   1'b1, 4'h3, 32'hDEAD_BEEF, 24'h123456},
        '{8'd2,   1'b0, 4'h8, 32'h0F0F_0F0F, 24'hFFFFFF},
        '{8'd3,   1'b1, 4'h1, 32'h8000_0001, 24'h000000},
        '{8'd4,   1'b1, 4'hC, 32'h7654_3210, 24'hABCDEF},
        '{8'd5,   1'b1, 4'hF, 32'hFFFF_FFFF, 24'h000004},
        '{8'h80,  1'b0, 4'h2, 32'h1357_9BDF, 24'h00FF00},
        '{8'hFF,  1'b1, 4'hF, 32'h2468_ACE0, 24'h800000}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic            m_we, m_cyc, m_stb;
    logic [3:0]      m_sel;
    logic [31:0]     m_adr, m_wdat, m_rdat;
    logic            m_ack;
    logic [S-1:0]    s_we, s_cyc, s_stb, s_ack, s_irq;
    logic [S*4-1:0]  s_sel;
    logic [S*32-1:0] s_adr, s_wdat, s_rdat;

    wbx_fabric #(.NUM_PERIPH(NP), .ROM_SLOT(1'b1)) uut (
        .i_mst_we(m_we), .i_mst_cyc(m_cyc), .i_mst_stb(m_stb), .i_mst_sel(m_sel),
        .i_mst_adr(m_adr), .i_mst_wdat(m_wdat), .o_mst_rdat(m_rdat), .o_mst_ack(m_ack),
        .o_slv_we(s_we), .o_slv_cyc(s_cyc), .o_slv_stb(s_stb), .o_slv_sel(s_sel),
        .o_slv_adr(s_adr), .o_slv_wdat(s_wdat), .i_slv_ack(s_ack), .i_slv_rdat(s_rdat),
        .i_slv_irq(s_irq)
    );

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    task automatic drive(input vec_t v);
        @(posedge clk);
        m_we = v.we; m_cyc = 1'b1; m_stb = 1'b1; m_sel = v.sel;
        m_wdat = v.wdat; m_adr = {v.idx, v.lo};
        @(negedge clk);
    endtask

    // expected per-slot bundle {we,cyc,stb,sel,adr,wdat}
    function automatic logic [70:0] exp_slot(input vec_t v, input int j);
        if (int'(v.idx) == j) return {v.we, 1'b1, 1'b1, v.sel, 8'h00, v.lo, v.wdat};
        return '0;
    endfunction

    function automatic logic [70:0] got_slot(input int j);
        return {s_we[j], s_cyc[j], s_stb[j], s_sel[j*4 +: 4], s_adr[j*32 +: 32],
                s_wdat[j*32 +: 32]};
    endfunction

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        m_we = 0; m_cyc = 0; m_stb = 0; m_sel = '0; m_adr = '0; m_wdat = '0;
        for (int j = 0; j < S; j++) s_rdat[j*32 +: 32] = 32'hC0DE_0000 | 32'(j * 32'h111);
        s_ack = 5'b10110;
        s_irq = 5'b01101;
        @(negedge clk);

        // idle master: no slot sees activity (R2, R8)
        chk(s_cyc == '0 && s_stb == '0 && s_we == '0, "R8 idle",
            {s_cyc, s_stb, s_we}, 0);
        for (int j = 1; j < S; j++)
            chk(got_slot(j) == '0, "R2 idle slot", got_slot(j), 0);

        // table walk: R1 R2 R3 R4 R5 R6
        for (int k = 0; k < 8; k++) begin
            drive(TBL[k]);
            for (int j = 0; j < S; j++)
                chk(got_slot(j) == exp_slot(TBL[k], j),
                    (int'(TBL[k].idx) == j) ? "R1/R3 selected slot" : "R2 unselected slot",
                    got_slot(j), exp_slot(TBL[k], j));
            if (int'(TBL[k].idx) < S) begin
                chk(m_rdat == s_rdat[int'(TBL[k].idx)*32 +: 32] && m_ack == s_ack[TBL[k].idx],
                    "R4 read path", {m_ack, m_rdat},
                    {s_ack[TBL[k].idx], s_rdat[int'(TBL[k].idx)*32 +: 32]});
            end else begin
                chk(m_ack == 1'b0, "R5 unmapped ack", m_ack, 0);
                chk(m_rdat == 32'h0000_000D, "R6 irq word", m_rdat, 32'hD);
            end
        end

        // R4: ack change on the selected slot shows up the same cycle
        drive(TBL[2]);
        s_ack[2] = 1'b0;
        #1;
        chk(m_ack == 1'b0, "R4 ack same cycle low", m_ack, 0);
        s_ack[2] = 1'b1;
        #1;
        chk(m_ack == 1'b1, "R4 ack same cycle high", m_ack, 1);
        s_rdat[2*32 +: 32] = 32'hA5A5_5A5A;
        #1;
        chk(m_rdat == 32'hA5A5_5A5A, "R4 rdat same cycle", m_rdat, 32'hA5A5_5A5A);

        // R6: all interrupts high, upper bits stay zero
        s_irq = '1;
        drive(TBL[6]);
        chk(m_rdat == 32'h0000_001F, "R6 all irq", m_rdat, 32'h1F);
        s_irq = 5'b10000;
        #1;
        chk(m_rdat == 32'h0000_0010, "R6 top slot irq", m_rdat, 32'h10);

        // R7: top slot (index NP) reachable, index NP+1 unmapped
        drive('{8'(NP), 1'b0, 4'h5, 32'h0, 24'h000ABC});
        chk(s_cyc == 5'b10000 && s_adr[NP*32 +: 32] == 32'h0000_0ABC, "R7 top slot",
            {s_cyc, s_adr[NP*32 +: 32]}, {5'b10000, 32'h0ABC});
        drive('{8'(NP + 1), 1'b0, 4'h5, 32'h0, 24'h000ABC});
        chk(s_cyc == '0 && m_ack == 1'b0, "R7 past top slot", {s_cyc, m_ack}, 0);

        // R5: unmapped with write strobes set, nothing forwarded
        drive('{8'h40, 1'b1, 4'hF, 32'hFFFF_FFFF, 24'hFFFFFF});
        chk(s_we == '0 && s_stb == '0 && s_wdat == '0, "R5 unmapped write",
            {s_we, s_stb}, 0);

        finish_run();
    end
endmodule